// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

A serial memory on a two-wire bus starts its internal write cycle as soon as the host ends a write transfer with a stop condition. Until that cycle is over, the memory does not acknowledge its own address. This sequencer sits on the host side and uses that missing acknowledge as a busy flag. It needs no fixed wait. Once a command is accepted, it sends a start condition and then the device address byte with the direction bit cleared (write). When the byte comes back not acknowledged, it sends a stop and tries again from a fresh start. When the byte is acknowledged, the memory is idle again, and the bus is handed to the next operation.

The command carries the device address and the kind of operation that follows. If a write follows, the bus is left open after the acknowledged address byte, so the caller can go on straight away with the word address and data. If a read follows, the sequencer closes the bus with a stop first. A poll budget limits the number of attempts. When the budget runs out, the sequencer closes the bus and reports an error instead of completion. Conditions and bytes on the bus are not generated here. Each one is requested from a separate bit-level engine through a request/completion pair.

Top module: `ack_poll_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cmd_ready` is 1 and `eng_req`, `done` and `err` are 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. In the next cycle `cmd_ready` is 0, and `eng_req` is 1 with `eng_op` = 0 (start condition). No idle cycles are inserted.
- R3: When a start request completes, the next request is `eng_op` = 1 (byte), and `eng_byte` holds the accepted address in bits [ADDR_W:1] with bit 0 = 0 (write direction).
- R4: When an address byte completes with `eng_nack` = 1, and the poll budget is not used up, the sequencer requests a stop (`eng_op` = 2) and then a new start. Every poll is the triple start, byte, stop.
- R5: When the address byte completes with `eng_nack` = 0 and the next operation is a write, no stop is requested. In the next cycle `done` pulses with `done_bus_open` = 1.
- R6: When the address byte completes acknowledged and the next operation is a read, a stop is requested. `done` pulses with `done_bus_open` = 0 in the cycle after that stop completes.
- R7: After MAX_POLLS consecutive not-acknowledged polls, the sequencer requests a stop and then pulses `err` instead of `done`. No more than MAX_POLLS starts are issued per command.
- R8: `done` and `err` are single-cycle pulses, never high together. `cmd_ready` is 1 again in the cycle in which either one is high.
- R9: While `eng_req` is 1 and `eng_done` is 0, `eng_req`, `eng_op` and `eng_byte` hold their values.
- R10: `cmd_valid`, `cmd_addr` and `cmd_is_write` are ignored while `cmd_ready` is 0. The bytes sent and the bus-open result come from the accepted command only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be accepted |
| cmd_is_write | input | 1 | 1: a write follows polling, 0: a read follows |
| cmd_addr | input | ADDR_W | Device address to poll |
| eng_req | output | 1 | Request pending to the bit engine |
| eng_op | output | 2 | 0 start, 1 byte, 2 stop |
| eng_byte | output | ADDR_W+1 | Byte to send when eng_op is 1 |
| eng_done | input | 1 | Engine completes the pending request |
| eng_nack | input | 1 | With eng_done on a byte: 1 when no acknowledge was seen |
| done | output | 1 | One-cycle pulse: device acknowledged |
| done_bus_open | output | 1 | Valid with done: 1 when the bus is left open for a write |
| err | output | 1 | One-cycle pulse: poll budget exhausted |

## Verification
A wrong internal state shows up at the engine port within one request. A misrouted state issues the wrong operation code, or adds or drops a stop, at the very next completion. That is visible as a change in the logged start/byte/stop sequence. A poll counter that is off by one gives one start too many or too few before `err`, so the sweep over 0 to MAX_POLLS+1 refusals finds it at the boundary. A wrong latch of the command shows in the address byte of the first poll, or in `done_bus_open` on the completion pulse.

// File: rtl/apc_pkg.sv
package apc_pkg;

  // Engine request codes (port encoding)
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } op_e;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_STOP_RETRY,
    ST_STOP_READ,
    ST_STOP_FAIL
  } st_e;

endpackage

// File: rtl/apc_poll_limit.sv
module apc_poll_limit #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
    end else if (bump) begin
      count_q <= count_q + 1'b1;
    end
  end

  // The refusal being judged now is the final permitted one
  assign last = (count_q == CW'(MAX_POLLS - 1));

endmodule

// File: rtl/apc_bus_req.sv
module apc_bus_req
  import apc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic [BYTE_W-1:0] launch_byte,
  input  logic              eng_done,
  output logic              eng_req,
  output op_e               eng_op,
  output logic [BYTE_W-1:0] eng_byte,
  output logic              complete
);

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_req  <= 1'b0;
      eng_op   <= OP_START;
      eng_byte <= '0;
    end else if (launch) begin
      eng_req  <= 1'b1;
      eng_op   <= launch_op;
      eng_byte <= launch_byte;
    end else if (eng_req && eng_done) begin
      eng_req  <= 1'b0;
    end
  end

  assign complete = eng_req && eng_done;

endmodule

// File: rtl/apc_fsm.sv
module apc_fsm
  import apc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  logic wr_next,
  input  logic complete,
  input  logic nack,
  input  logic poll_last,
  output logic ready,
  output logic accept,
  output logic launch,
  output op_e  launch_op,
  output logic poll_bump,
  output logic done_set,
  output logic open_set,
  output logic err_set
);

  st_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign ready = (st_q == ST_IDLE);

  always_comb begin
    st_d      = st_q;
    accept    = 1'b0;
    launch    = 1'b0;
    launch_op = OP_START;
    poll_bump = 1'b0;
    done_set  = 1'b0;
    open_set  = 1'b0;
    err_set   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          accept    = 1'b1;
          launch    = 1'b1;
          launch_op = OP_START;
          st_d      = ST_START;
        end
      end
      ST_START: begin
        if (complete) begin
          launch    = 1'b1;
          launch_op = OP_BYTE;
          st_d      = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (complete) begin
          if (!nack) begin
            if (wr_next) begin
              done_set = 1'b1;
              open_set = 1'b1;
              st_d     = ST_IDLE;
            end else begin
              launch    = 1'b1;
              launch_op = OP_STOP;
              st_d      = ST_STOP_READ;
            end
          end else begin
            poll_bump = 1'b1;
            launch    = 1'b1;
            launch_op = OP_STOP;
            st_d      = poll_last ? ST_STOP_FAIL : ST_STOP_RETRY;
          end
        end
      end
      ST_STOP_RETRY: begin
        if (complete) begin
          launch    = 1'b1;
          launch_op = OP_START;
          st_d      = ST_START;
        end
      end
      ST_STOP_READ: begin
        if (complete) begin
          done_set = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      ST_STOP_FAIL: begin
        if (complete) begin
          err_set = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ack_poll_ctrl.sv
module ack_poll_ctrl
  import apc_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int MAX_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [ADDR_W:0]   eng_byte,
  input  logic              eng_done,
  input  logic              eng_nack,
  output logic              done,
  output logic              done_bus_open,
  output logic              err
);
  localparam int BYTE_W = ADDR_W + 1;

  logic              accept, launch, complete, poll_bump, poll_last;
  logic              done_set, open_set, err_set;
  op_e               launch_op, op_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] launch_byte;

  // Command capture, only on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      wr_q   <= cmd_is_write;
      addr_q <= cmd_addr;
    end
  end

  // Address byte always carries the write direction bit
  assign launch_byte = {addr_q, 1'b0};

  apc_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .wr_next   (wr_q),
    .complete  (complete),
    .nack      (eng_nack),
    .poll_last (poll_last),
    .ready     (cmd_ready),
    .accept    (accept),
    .launch    (launch),
    .launch_op (launch_op),
    .poll_bump (poll_bump),
    .done_set  (done_set),
    .open_set  (open_set),
    .err_set   (err_set)
  );

  apc_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .bump  (poll_bump),
    .last  (poll_last)
  );

  apc_bus_req #(.BYTE_W(BYTE_W)) u_req (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_op   (launch_op),
    .launch_byte (launch_byte),
    .eng_done    (eng_done),
    .eng_req     (eng_req),
    .eng_op      (op_q),
    .eng_byte    (eng_byte),
    .complete    (complete)
  );

  assign eng_op = op_q;

  // Registered completion flags
  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      done_bus_open <= 1'b0;
      err           <= 1'b0;
    end else begin
      done          <= done_set;
      done_bus_open <= open_set;
      err           <= err_set;
    end
  end

endmodule

// File: rtl/ack_poll_ctrl_chk.sv
module ack_poll_ctrl_chk #(
  parameter int ADDR_W    = 7,
  parameter int MAX_POLLS = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              eng_req,
  input logic [1:0]        eng_op,
  input logic [ADDR_W:0]   eng_byte,
  input logic              eng_done,
  input logic              eng_nack,
  input logic              done,
  input logic              done_bus_open,
  input logic              err
);
  int starts_q;

  always_ff @(posedge clk) begin
    if (rst || (cmd_valid && cmd_ready)) starts_q <= 0;
    else if (eng_req && eng_done && eng_op == 2'd0) starts_q <= starts_q + 1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cmd_ready && !eng_req && !done && !err));

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (eng_req && eng_op == 2'd0 && !cmd_ready));

  // R3
  start_then_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done && eng_op == 2'd0) |=> (eng_req && eng_op == 2'd1 && !eng_byte[0]));

  // R4
  refuse_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done && eng_op == 2'd1 && eng_nack) |=> (eng_req && eng_op == 2'd2));

  // R5
  open_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_bus_open) |-> $past(eng_req && eng_done && eng_op == 2'd1 && !eng_nack));

  // R6
  closed_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !done_bus_open) |-> $past(eng_req && eng_done && eng_op == 2'd2));

  // R7
  poll_budget_chk: assert property (@(posedge clk) disable iff (rst)
    starts_q <= MAX_POLLS);

  // R8
  exclusive_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R8
  ready_on_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> cmd_ready);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));

endmodule

bind ack_poll_ctrl ack_poll_ctrl_chk #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .eng_req       (eng_req),
  .eng_op        (eng_op),
  .eng_byte      (eng_byte),
  .eng_done      (eng_done),
  .eng_nack      (eng_nack),
  .done          (done),
  .done_bus_open (done_bus_open),
  .err           (err)
);

// File: tb/ack_poll_ctrl_bench.sv
module ack_poll_ctrl_bench;
  localparam int AW   = 7;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_is_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_ready, eng_req, done, done_bus_open, err;
  logic [1:0]    eng_op;
  logic [AW:0]   eng_byte;
  logic          eng_done = 1'b0, eng_nack = 1'b0;

  int checks = 0, errors = 0;
  int lat = 1, nacks_left = 0, wc = 0, nops = 0, done_cnt = 0, err_cnt = 0;
  logic open_seen = 1'b0;
  logic [1:0]  log_op   [64];
  logic [AW:0] log_byte [64];

  ack_poll_ctrl #(.ADDR_W(AW), .MAX_POLLS(MAXP)) u_ack_poll_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_write(cmd_is_write), .cmd_addr(cmd_addr), .eng_req(eng_req),
    .eng_op(eng_op), .eng_byte(eng_byte), .eng_done(eng_done),
    .eng_nack(eng_nack), .done(done), .done_bus_open(done_bus_open), .err(err)
  );

  // Engine model and output monitor, on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      eng_done = 1'b0; eng_nack = 1'b0; wc = 0;
    end else begin
      if (done) begin done_cnt++; open_seen = done_bus_open; end
      if (err) err_cnt++;
      if (eng_done) begin
        eng_done = 1'b0; eng_nack = 1'b0; wc = 0;
      end else if (eng_req) begin
        wc++;
        if (wc >= lat) begin
          eng_done = 1'b1;
          eng_nack = (eng_op == 2'd1) && (nacks_left > 0);
          if (eng_nack) nacks_left--;
          if (nops < 64) begin log_op[nops] = eng_op; log_byte[nops] = eng_byte; end
          nops++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int wr, input int k, input int l);
    logic [AW-1:0] a;
    int polls, nexp;
    a = AW'((k * 37 + l * 11 + wr * 5 + 3) & 7'h7f);
    lat = l; nacks_left = k; nops = 0; done_cnt = 0; err_cnt = 0; open_seen = 1'b0;
    @(posedge clk); #5;
    cmd_valid = 1'b1; cmd_is_write = wr[0]; cmd_addr = a;
    @(posedge clk); #5;
    chk("R2", "ready after accept", int'(cmd_ready), 0);
    chk("R2", "request after accept", int'(eng_req), 1);
    // R10: junk command while busy
    cmd_valid = 1'b1; cmd_is_write = ~wr[0]; cmd_addr = ~a;
    @(posedge clk); #5;
    cmd_valid = 1'b0;
    for (int t = 0; t < 500 && done_cnt == 0 && err_cnt == 0; t++) @(posedge clk);
    if (done_cnt == 0 && err_cnt == 0) begin
      errors++; checks++;
      $display("FAIL R7 watchdog: actual 0 expected 1 completion");
    end
    repeat (6) @(posedge clk);
    #5;
    polls = (k < MAXP) ? k + 1 : MAXP;
    nexp  = (k < MAXP) ? 3 * k + 2 + (wr ? 0 : 1) : 3 * MAXP;
    chk((k < MAXP) ? (wr ? "R5" : "R6") : "R7", "op count", nops, nexp);
    for (int i = 0; i < nexp && i < nops; i++) begin
      chk("R4", "op code", int'(log_op[i]), i % 3);
      if (i % 3 == 1) chk("R3", "address byte", int'(log_byte[i]), int'({a, 1'b0}));
    end
    chk("R7", "start count", (nops + 2) / 3, polls);
    chk("R8", "done pulses", done_cnt, (k < MAXP) ? 1 : 0);
    chk("R7", "err pulses", err_cnt, (k < MAXP) ? 0 : 1);
    chk(wr ? "R5" : "R6", "bus open", int'(open_seen), (wr != 0 && k < MAXP) ? 1 : 0);
    chk("R8", "ready after end", int'(cmd_ready), 1);
    chk("R10", "no extra ops", int'(eng_req), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "ready in reset", int'(cmd_ready), 1);
    chk("R1", "req in reset", int'(eng_req), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "err in reset", int'(err), 0);
    rst = 1'b0;
    for (int wr = 0; wr < 2; wr++)
      for (int k = 0; k <= MAXP + 1; k++)
        for (int l = 1; l <= 3; l++)
          run(wr, k, l);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule